// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a 16-bit destination word left or right while filling the vacated positions from a second 16-bit source word. It is the datapath behind double-precision shift operations in an integer execution pipeline. A request carries both words, a raw shift count, a direction bit and the current arithmetic flags. One clock later the block returns the shifted word and a new flag set. Counts from 17 to 31 are fully defined: once the source word has been used up, the destination is folded back in as fill.

Internally the three words destination, source and destination are laid side by side into a 48-bit field. A left shift takes a 16-bit window whose lowest bit sits 32 − count positions from the bottom of that field. A right shift takes the window starting at bit count. The carry is the bit just outside the window on the side the data leaves from. A two-state machine (ST_IDLE, ST_ISSUE) holds the output strobe. ST_IDLE moves to ST_ISSUE on an accepted request. ST_ISSUE stays there while requests keep arriving and returns to ST_IDLE on a cycle with no request.

Top module: `fsh_unit`

## Requirements
- R1: Only bits [4:0] of `in_count` set the shift amount; bits [7:5] have no effect on the result or on the flags.
- R2: When the masked count is zero, `out_result` equals `in_dst` and `out_flags` equals `in_flags`, for either direction.
- R3: Left shift, count 1..16: the result is the upper 16 bits of the 32-bit word {dst, src} shifted left by count. At count 16 the result equals src.
- R4: Left shift, count 17..31: the result is the R3 value ORed with the upper 16 bits of the 32-bit word dst shifted left by (count − 16).
- R5: Left shift carry is bit (32 − count) of {dst, src}. Left shift overflow is carry XOR result bit 15.
- R6: Right shift: the result is the lower 16 bits of {src, dst} shifted right by count. For count 17..31 it is also ORed with dst shifted left by (32 − count).
- R7: Right shift carry is dst bit (count − 1) for count 1..16 and src bit (count − 17) for count 17..31. Right shift overflow is result bit 15 XOR result bit 14.
- R8: For a nonzero count the flags are laid out as bit0 carry, bit1 parity, bit2 auxiliary, bit3 zero, bit4 sign and bit5 overflow. Sign is result bit 15. Zero is set when the result is 0. Parity is set when result bits [7:0] hold an even number of ones. Auxiliary is 0.
- R9: `in_dir` = 0 selects a left shift and 1 selects a right shift. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, with the result and flags of that request. Synchronous active-high `rst` clears `out_valid`, `out_result` and `out_flags` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| in_dir | input | 1 | 0 = left, 1 = right |
| in_dst | input | 16 | Word being shifted |
| in_src | input | 16 | Word supplying the fill bits |
| in_count | input | 8 | Raw shift count, low 5 bits used |
| in_flags | input | 6 | Incoming flags, same layout as out_flags |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 16 | Shifted word |
| out_flags | output | 6 | Updated flags (layout in R8) |

## Verification
Two things can fall in the same cycle. One is the capture of a new request, which may be a zero-count pass-through that must copy the incoming flags. The other is the presentation of the previous request's shifted result with freshly computed flags. Long back-to-back runs mix zero counts and shifts in both directions, so the output register is reloaded every cycle while the state machine stays in ST_ISSUE. The runs are broken by idle gaps that send it back to ST_IDLE. Every clock, a behavioural model in the bench queues the expected strobe, result and flags and compares them with the outputs, so a stale or mixed-up capture shows up in the cycle where it happens.

// File: rtl/fsh_pkg.sv
`timescale 1ns/1ps
package fsh_pkg;

    // bit5 .. bit0 : overflow, sign, zero, auxiliary, parity, carry
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } fsh_flags_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } fsh_dir_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } fsh_state_t;

endpackage

// File: rtl/fsh_window.sv
`timescale 1ns/1ps
module fsh_window #(
    parameter int W     = 16,
    parameter int IDX_W = 6
) (
    input  logic [3*W-1:0]  tri_bus,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] cy_idx,
    output logic [W-1:0]    slice,
    output logic            cy_bit
);
    logic [3*W-1:0] shifted;
    logic           unused_upper;

    assign shifted      = tri_bus >> lo_idx;
    assign slice        = shifted[W-1:0];
    assign unused_upper = ^shifted[3*W-1:W];
    assign cy_bit       = tri_bus[cy_idx];
endmodule

// File: rtl/fsh_flag_gen.sv
`timescale 1ns/1ps
module fsh_flag_gen
    import fsh_pkg::*;
#(
    parameter int W     = 16,
    parameter int PAR_W = 8
) (
    input  logic [W-1:0] res,
    input  fsh_dir_t     dir,
    input  logic         cry,
    output fsh_flags_t   flg
);
    always_comb begin
        flg.cry = cry;
        flg.par = ~^res[PAR_W-1:0];
        flg.aux = 1'b0;
        flg.zro = (res == '0);
        flg.sgn = res[W-1];
        if (dir == DIR_LEFT) flg.ovf = cry ^ res[W-1];
        else                 flg.ovf = res[W-1] ^ res[W-2];
    end
endmodule

// File: rtl/fsh_unit.sv
`timescale 1ns/1ps
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int W     = 16,
    parameter int RAW_W = 8,
    parameter int CNT_W = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_dir,
    input  logic [W-1:0]                  in_dst,
    input  logic [W-1:0]                  in_src,
    input  logic [RAW_W-1:0]              in_count,
    input  logic [$bits(fsh_flags_t)-1:0] in_flags,
    output logic                          out_valid,
    output logic [W-1:0]                  out_result,
    output logic [$bits(fsh_flags_t)-1:0] out_flags
);
    localparam int TRI_W = 3 * W;
    localparam int IDX_W = $clog2(TRI_W);

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             unused_cnt_hi;
    logic [TRI_W-1:0] tri_bus;
    fsh_dir_t         dir;

    assign cnt           = in_count[CNT_W-1:0];
    assign unused_cnt_hi = ^in_count[RAW_W-1:CNT_W];
    assign cnt_zero      = (cnt == '0);
    assign tri_bus       = {in_dst, in_src, in_dst};
    assign dir           = fsh_dir_t'(in_dir);

    // index 0: left window, index 1: right window
    logic [IDX_W-1:0] lo_idx [2];
    logic [IDX_W-1:0] cy_idx [2];
    logic [W-1:0]     slice  [2];
    logic             cy_bit [2];

    for (genvar g = 0; g < 2; g++) begin : g_win
        if (g == 0) begin : g_left
            assign lo_idx[g] = IDX_W'(2 * W) - IDX_W'(cnt);
            assign cy_idx[g] = lo_idx[g] + IDX_W'(W);
        end else begin : g_right
            assign lo_idx[g] = IDX_W'(cnt);
            assign cy_idx[g] = lo_idx[g] - IDX_W'(1);
        end
        fsh_window #(.W(W), .IDX_W(IDX_W)) u_win (
            .tri_bus (tri_bus),
            .lo_idx  (lo_idx[g]),
            .cy_idx  (cy_idx[g]),
            .slice   (slice[g]),
            .cy_bit  (cy_bit[g])
        );
    end

    logic [W-1:0] shift_res;
    logic         shift_cy;
    fsh_flags_t   gen_flags;

    assign shift_res = (dir == DIR_LEFT) ? slice[0]  : slice[1];
    assign shift_cy  = (dir == DIR_LEFT) ? cy_bit[0] : cy_bit[1];

    fsh_flag_gen #(.W(W), .PAR_W(8)) u_flags (
        .res (shift_res),
        .dir (dir),
        .cry (shift_cy),
        .flg (gen_flags)
    );

    logic [W-1:0] next_res;
    fsh_flags_t   next_flg;

    assign next_res = cnt_zero ? in_dst : shift_res;
    assign next_flg = cnt_zero ? fsh_flags_t'(in_flags) : gen_flags;

    // state register
    fsh_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)  state_d = ST_ISSUE;
            ST_ISSUE: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_flags  <= '0;
        end else if (in_valid) begin
            out_result <= next_res;
            out_flags  <= next_flg;
        end
    end

    assign out_valid = (state_q == ST_ISSUE);

    // checks on the registered outputs
    fsh_flags_t out_view;
    assign out_view = fsh_flags_t'(out_flags);

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_zero_count_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt_zero) |=>
        (out_result == $past(in_dst)) && (out_flags == $past(in_flags)));

    assert_aux_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cnt_zero) |=> !out_view.aux);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cnt_zero) |=> (out_view.zro == (out_result == '0)));

    assert_left_ovf_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cnt_zero && !in_dir) |=>
        (out_view.ovf == (out_view.cry ^ out_result[W-1])));

    assert_right_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cnt_zero && in_dir) |=>
        (out_view.ovf == (out_result[W-1] ^ out_result[W-2])));
endmodule

// File: tb/fsh_unit_tb.sv
`timescale 1ns/1ps
module fsh_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_dir;
    logic [15:0] in_dst, in_src;
    logic [7:0]  in_count;
    logic [5:0]  in_flags;
    logic        out_valid;
    logic [15:0] out_result;
    logic [5:0]  out_flags;

    always #10 clk = ~clk;

    fsh_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_dst(in_dst), .in_src(in_src), .in_count(in_count), .in_flags(in_flags),
        .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit          exp_v_q[$];
    logic [15:0] exp_r_q[$];
    logic [5:0]  exp_f_q[$];
    string       tag_r_q[$];
    string       tag_f_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural model from the requirements
    function automatic void model(input bit dir, input logic [15:0] d, input logic [15:0] s,
                                  input logic [7:0] raw, input logic [5:0] fin,
                                  output logic [15:0] r, output logic [5:0] f);
        int c;
        logic [31:0] t;
        logic [31:0] w;
        logic cf;
        logic of;
        c = int'(raw) % 32;
        if (c == 0) begin
            r = d;
            f = fin;
            return;
        end
        if (!dir) begin
            t = {d, s};
            w = t << c;
            if (c > 16) w = w | ({16'h0, d} << (c - 16));
            r  = w[31:16];
            cf = t[32 - c];
            of = cf ^ r[15];
        end else begin
            t = {s, d};
            w = t >> c;
            if (c > 16) w = w | ({16'h0, d} << (32 - c));
            r  = w[15:0];
            cf = (c <= 16) ? d[c - 1] : s[c - 17];
            of = r[15] ^ r[14];
        end
        f = {of, r[15], (r == 16'h0), 1'b0, ($countones(r[7:0]) % 2 == 0), cf};
    endfunction

    task automatic compare_now();
        bit          v;
        logic [15:0] er;
        logic [5:0]  ef;
        string       tr;
        string       tf;
        if (exp_v_q.size() == 0) return;
        v  = exp_v_q.pop_front();
        er = exp_r_q.pop_front();
        ef = exp_f_q.pop_front();
        tr = tag_r_q.pop_front();
        tf = tag_f_q.pop_front();
        check(out_valid == v, "R9", "out_valid", int'(out_valid), int'(v));
        if (v) begin
            check(out_result == er, tr, "result", int'(out_result), int'(er));
            check(out_flags == ef, tf, "flags", int'(out_flags), int'(ef));
        end
    endtask

    task automatic drive(input bit v, input bit dir, input logic [15:0] d,
                         input logic [15:0] s, input logic [7:0] raw,
                         input logic [5:0] fin);
        logic [15:0] r;
        logic [5:0]  f;
        int          c;
        string       pre;
        @(negedge clk);
        compare_now();
        in_valid = v; in_dir = dir; in_dst = d; in_src = s;
        in_count = raw; in_flags = fin;
        model(dir, d, s, raw, fin, r, f);
        c   = int'(raw) % 32;
        pre = (raw[7:5] != 3'b000) ? "R1 " : "";
        exp_v_q.push_back(v);
        exp_r_q.push_back(r);
        exp_f_q.push_back(f);
        if (c == 0) begin
            tag_r_q.push_back({pre, "R2"});
            tag_f_q.push_back({pre, "R2"});
        end else if (!dir) begin
            tag_r_q.push_back({pre, (c > 16) ? "R4" : "R3"});
            tag_f_q.push_back({pre, "R5 R8"});
        end else begin
            tag_r_q.push_back({pre, "R6"});
            tag_f_q.push_back({pre, "R7 R8"});
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_dir = 1'b0;
        in_dst = '0; in_src = '0; in_count = '0; in_flags = '0;
        repeat (3) @(negedge clk);
        // reset state
        check(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
        check(out_result == 16'h0, "R9", "reset out_result", int'(out_result), 0);
        check(out_flags == 6'h0, "R9", "reset out_flags", int'(out_flags), 0);
        rst = 1'b0;

        // zero-count pass-through, both directions, and masked-to-zero counts
        drive(1, 0, 16'h1234, 16'hABCD, 8'h00, 6'h2A);
        drive(1, 1, 16'h8001, 16'h0000, 8'h20, 6'h15);
        drive(1, 0, 16'hFFFF, 16'h5555, 8'hE0, 6'h3F);
        // upper count bits ignored
        drive(1, 0, 16'h8001, 16'h4000, 8'hE3, 6'h00);
        drive(1, 1, 16'h8001, 16'h4000, 8'h43, 6'h00);
        // left shifts across the 16/17 boundary
        for (int c = 1; c < 32; c++) drive(1, 0, 16'hC35A, 16'h96E1, 8'(c), 6'h00);
        drive(1, 0, 16'h0000, 16'h0000, 8'd5, 6'h3F);
        drive(1, 0, 16'h8000, 16'h0000, 8'd1, 6'h00);
        drive(1, 0, 16'h4000, 16'h0000, 8'd1, 6'h00);
        // idle gap returns the strobe low
        drive(0, 0, 16'h0, 16'h0, 8'd0, 6'h0);
        drive(0, 0, 16'h0, 16'h0, 8'd0, 6'h0);
        // right shifts across the boundary
        for (int c = 1; c < 32; c++) drive(1, 1, 16'h3CA5, 16'h7E18, 8'(c), 6'h00);
        drive(1, 1, 16'h0001, 16'h0000, 8'd1, 6'h00);
        drive(1, 1, 16'h0000, 16'h0001, 8'd17, 6'h00);
        drive(1, 1, 16'h0000, 16'h8000, 8'd31, 6'h00);
        drive(0, 0, 16'h0, 16'h0, 8'd0, 6'h0);
        // back-to-back mix of zero counts and shifts with gaps
        for (int i = 0; i < 600; i++) begin
            logic [7:0] raw;
            raw = 8'($urandom);
            if (i % 5 == 0) raw = raw & 8'hE0;
            drive(($urandom % 4) != 0, 1'($urandom), 16'($urandom), 16'($urandom),
                  raw, 6'($urandom));
        end
        drive(0, 0, 16'h0, 16'h0, 8'd0, 6'h0);
        @(negedge clk);
        compare_now();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule